// File: doc/BRIEF.md
# Byte-to-Word Packer with Swap Placement

This block sits on the narrow side of a 36-bit FIFO. It accepts 9-bit byte writes on a 36-bit port. A lane select says which end of the port carries the byte. The block collects four accepted bytes and pushes them to a FIFO write interface as one 36-bit word. The word is split into four byte positions: A at bits 35..27, B at 26..18, C at 17..9 and D at 8..0. A 2-bit swap mode decides which position each byte in the sequence fills. This lets the far side read the word in its natural order, whatever order the producer writes in.

A write with size code 11 does not take part in byte assembly. It loads the whole 36-bit port value into a mailbox register. A combinational parity flag checks one byte lane of the port against odd or even parity, as chosen by a select input.

Top module: `byte_word_packer`

## Requirements
- R1: With swap mode 00, the bytes written in sequence fill positions A, B, C, D in that order. A is bits 35..27 and D is bits 8..0. When `big_lane` is 1, the byte is taken from `din[35:27]`.
- R2: When `big_lane` is 0, the byte is taken from `din[8:0]`. The other port bits have no effect on the assembled word.
- R3: `fifo_push` is high for exactly one cycle. It is visible in the cycle after the clock edge that accepts the fourth byte of a word, and `fifo_word` then holds the assembled word. The push stays low after the first, second and third bytes.
- R4: Swap mode 01 reverses the order: the byte sequence fills D, C, B, A.
- R5: Swap mode 10 exchanges the halfwords: the byte sequence fills C, D, A, B.
- R6: Swap mode 11 exchanges the bytes within each halfword: the byte sequence fills B, A, D, C.
- R7: The swap mode is sampled on the first byte of each word. A change of `swap_mode` during bytes two to four does not affect that word.
- R8: A byte is accepted only at a rising clock edge where all of these hold: `sel_n` is 0, `wr_mode` is 1, `en` is 1, `fifo_full` is 0 and `size_code` is not 11. Any other write attempt leaves the byte count and the partial word unchanged.
- R9: When `sel_n` is 0, `wr_mode` is 1, `en` is 1 and `size_code` is 11, the whole of `din` is loaded into `mbox_data` at that edge, whatever the value of `fifo_full`. Such a write neither counts as a byte nor causes a push. `mbox_data` holds its value otherwise.
- R10: `par_err` is combinational. It checks `din[35:27]` when `big_lane` is 1 and `din[17:9]` when `big_lane` is 0. With `odd_par` at 1, it is high when the lane has an even number of ones. With `odd_par` at 0, it is high when the lane has an odd number of ones.
- R11: A synchronous active-low reset clears the byte count, the partial word, `fifo_push`, `fifo_word` and `mbox_data`. The next four accepted bytes form a fresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| wr_mode | input | 1 | 1 = write access |
| en | input | 1 | Access enable |
| size_code | input | 2 | 11 = mailbox write, other values = byte write |
| swap_mode | input | 2 | Byte placement mode |
| big_lane | input | 1 | 1 = byte on bits 35..27, 0 = byte on bits 8..0 |
| odd_par | input | 1 | 1 = odd parity, 0 = even parity |
| din | input | 36 | Port data |
| fifo_full | input | 1 | FIFO full flag, blocks byte writes |
| fifo_push | output | 1 | One-cycle FIFO write strobe |
| fifo_word | output | 36 | Assembled word for the FIFO |
| mbox_data | output | 36 | Mailbox register contents |
| par_err | output | 1 | Parity error on the active lane |

## Verification
`fifo_push`, `fifo_word` and `mbox_data` are registered. They change at the edge that accepts the fourth byte or the mailbox write, so the bench samples them on the falling edge that follows that clock edge. The bench also checks that the push is low on the falling edge after each earlier byte and one cycle after the push. `par_err` is combinational, so it is read 1 ns after `din` and the selects change, with no clock edge between. Blocked and mailbox writes are placed in the middle of a word. Their lack of effect is then seen in the value of the word that completes afterwards.

// File: rtl/bwp_pkg.sv
// Package: shared sizes, the swap mode type and the placement mask.
// Assumes four bytes per word; the mask arithmetic relies on that.
package bwp_pkg;
    localparam int BYTE_W = 9;
    localparam int BYTES  = 4;

    typedef enum logic [1:0] {
        SWAP_NONE    = 2'b00,
        SWAP_REVERSE = 2'b01,
        SWAP_HALVES  = 2'b10,
        SWAP_INNER   = 2'b11
    } swap_e;

    // Position of the k-th byte is k XOR mask, where mask = -mode mod 4.
    function automatic logic [1:0] swap_mask(input logic [1:0] mode);
        return 2'b00 - mode;
    endfunction
endpackage

// File: rtl/bwp_lane_pick.sv
// Module: picks the data byte and the parity-checked lane from the port.
// Assumes the big lane is the top byte; the little data lane is the bottom
// byte and the little parity lane is the byte above it.
module bwp_lane_pick #(
    parameter int BYTE_W = 9,
    parameter int BYTES  = 4
) (
    input  logic [BYTE_W*BYTES-1:0] din,
    input  logic                    big_lane,
    output logic [BYTE_W-1:0]       data_byte,
    output logic [BYTE_W-1:0]       par_bits
);
    localparam int BIG_LO    = (BYTES - 1) * BYTE_W;
    localparam int LIT_LO    = 0;
    localparam int LIT_PAR_LO = BYTE_W;

    // Select the data lane and the parity lane from the lane select.
    always_comb begin
        data_byte = big_lane ? din[BIG_LO +: BYTE_W] : din[LIT_LO +: BYTE_W];
        par_bits  = big_lane ? din[BIG_LO +: BYTE_W] : din[LIT_PAR_LO +: BYTE_W];
    end
endmodule

// File: rtl/bwp_parity_chk.sv
// Module: odd/even parity checker over one lane.
// Assumes odd_sel = 1 means the lane must hold an odd count of ones.
module bwp_parity_chk #(
    parameter int W = 9
) (
    input  logic [W-1:0] bits,
    input  logic         odd_sel,
    output logic         err
);
    logic ones_odd;

    // Flag an error when the count parity disagrees with the selection.
    always_comb begin
        ones_odd = ^bits;
        err      = odd_sel ? !ones_odd : ones_odd;
    end
endmodule

// File: rtl/bwp_assembler.sv
// Module: counts accepted bytes, places each into its swap position and
// emits the completed word with a one-cycle push.
// Assumes take is already qualified; mode is sampled on the first byte.
module bwp_assembler
    import bwp_pkg::*;
#(
    parameter int BYTE_W = 9,
    parameter int BYTES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic [1:0]              mode_in,
    input  logic [BYTE_W-1:0]       byte_in,
    output logic                    push,
    output logic [BYTE_W*BYTES-1:0] word
);
    localparam int CNT_W  = $clog2(BYTES);
    localparam int WORD_W = BYTE_W * BYTES;

    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        mode_q;
    logic [1:0]        mode_use;
    logic [CNT_W-1:0]  pos;
    logic              first_b;
    logic              last_b;
    logic [BYTE_W-1:0] part_q [BYTES];
    logic [BYTE_W-1:0] part_n [BYTES];
    logic [WORD_W-1:0] word_n;
    logic              push_q;
    logic [WORD_W-1:0] word_q;

    // Decode where the incoming byte lands in the word.
    always_comb begin
        first_b  = (cnt_q == '0);
        last_b   = (cnt_q == CNT_W'(BYTES - 1));
        mode_use = first_b ? mode_in : mode_q;
        pos      = cnt_q ^ CNT_W'(swap_mask(mode_use));
    end

    genvar gi;
    generate
        for (gi = 0; gi < BYTES; gi++) begin : g_lane
            // Next value of this position: the new byte if it lands here.
            always_comb begin
                part_n[gi] = (take && pos == CNT_W'(gi)) ? byte_in : part_q[gi];
                word_n[(BYTES-1-gi)*BYTE_W +: BYTE_W] = part_n[gi];
            end

            // Hold the partial byte, cleared on reset and on word completion.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    part_q[gi] <= '0;
                end else if (take) begin
                    part_q[gi] <= last_b ? '0 : part_n[gi];
                end
            end
        end
    endgenerate

    // Byte counter and captured swap mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mode_q <= 2'b00;
        end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
            if (first_b) begin
                mode_q <= mode_in;
            end
        end
    end

    // Completed word register and one-cycle push strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_q <= 1'b0;
            word_q <= '0;
        end else begin
            push_q <= take && last_b;
            if (take && last_b) begin
                word_q <= word_n;
            end
        end
    end

    assign push = push_q;
    assign word = word_q;
endmodule

// File: rtl/byte_word_packer.sv
// Module: top of the byte-to-word packer. Qualifies port writes, routes
// size code 11 to the mailbox and the rest to the assembler, and reports
// parity of the active lane.
// Assumes the FIFO full flag is valid at the port clock edge.
module byte_word_packer
    import bwp_pkg::*;
#(
    parameter int BYTE_W = bwp_pkg::BYTE_W,
    parameter int BYTES  = bwp_pkg::BYTES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_n,
    input  logic                    wr_mode,
    input  logic                    en,
    input  logic [1:0]              size_code,
    input  logic [1:0]              swap_mode,
    input  logic                    big_lane,
    input  logic                    odd_par,
    input  logic [BYTE_W*BYTES-1:0] din,
    input  logic                    fifo_full,
    output logic                    fifo_push,
    output logic [BYTE_W*BYTES-1:0] fifo_word,
    output logic [BYTE_W*BYTES-1:0] mbox_data,
    output logic                    par_err
);
    localparam int WORD_W = BYTE_W * BYTES;
    localparam logic [1:0] SIZE_MBOX = 2'b11;

    logic              access;
    logic              mbox_hit;
    logic              byte_take;
    logic [BYTE_W-1:0] data_byte;
    logic [BYTE_W-1:0] par_bits;
    logic [WORD_W-1:0] mbox_q;

    // Qualify a port write and split it into mailbox and byte traffic.
    always_comb begin
        access    = !sel_n && wr_mode && en;
        mbox_hit  = access && (size_code == SIZE_MBOX);
        byte_take = access && (size_code != SIZE_MBOX) && !fifo_full;
    end

    bwp_lane_pick #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_pick (
        .din       (din),
        .big_lane  (big_lane),
        .data_byte (data_byte),
        .par_bits  (par_bits)
    );

    bwp_parity_chk #(.W(BYTE_W)) u_par (
        .bits    (par_bits),
        .odd_sel (odd_par),
        .err     (par_err)
    );

    bwp_assembler #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (byte_take),
        .mode_in (swap_mode),
        .byte_in (data_byte),
        .push    (fifo_push),
        .word    (fifo_word)
    );

    // Mailbox register: loads the whole port on a size-11 write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbox_q <= '0;
        end else if (mbox_hit) begin
            mbox_q <= din;
        end
    end

    assign mbox_data = mbox_q;
endmodule

// File: rtl/byte_word_packer_checker.sv
// Module: port-level properties of the packer, bound to the top module.
// Assumes reset is held for at least one clock edge at start.
module byte_word_packer_checker #(
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              wr_mode,
    input logic              en,
    input logic [1:0]        size_code,
    input logic              fifo_full,
    input logic [WORD_W-1:0] din,
    input logic              fifo_push,
    input logic [WORD_W-1:0] mbox_data
);
    logic chk_byte;
    logic chk_mbox;

    // Port-side view of an accepted byte and of a mailbox write.
    always_comb begin
        chk_byte = !sel_n && wr_mode && en && !fifo_full && size_code != 2'b11;
        chk_mbox = !sel_n && wr_mode && en && size_code == 2'b11;
    end

    // R3: a push follows an accepted byte at the previous edge.
    assert_push_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && $past(rst_n)) |-> $past(chk_byte));

    // R3: a push never lasts two cycles.
    assert_push_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |=> !fifo_push);

    // R8: a full FIFO at an edge means no push in the next cycle.
    assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !chk_mbox) |=> !fifo_push);

    // R9: a mailbox write loads the port value.
    assert_mbox_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chk_mbox |=> (mbox_data == $past(din)));

    // R9: without a mailbox write the mailbox holds its value.
    assert_mbox_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(chk_mbox)) |-> $stable(mbox_data));

    // R9: a mailbox write never causes a push.
    assert_mbox_no_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chk_mbox |=> !fifo_push);
endmodule

bind byte_word_packer byte_word_packer_checker #(.WORD_W(BYTE_W*BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .wr_mode   (wr_mode),
    .en        (en),
    .size_code (size_code),
    .fifo_full (fifo_full),
    .din       (din),
    .fifo_push (fifo_push),
    .mbox_data (mbox_data)
);

// File: tb/byte_word_packer_test.sv
`timescale 1ns/1ps
module byte_word_packer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        wr_mode = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  size_code = 2'b00;
    logic [1:0]  swap_mode = 2'b00;
    logic        big_lane = 1'b1;
    logic        odd_par = 1'b1;
    logic [35:0] din = '0;
    logic        fifo_full = 1'b0;
    logic        fifo_push;
    logic [35:0] fifo_word;
    logic [35:0] mbox_data;
    logic        par_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    byte_word_packer uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_mode(wr_mode), .en(en),
        .size_code(size_code), .swap_mode(swap_mode), .big_lane(big_lane),
        .odd_par(odd_par), .din(din), .fifo_full(fifo_full),
        .fifo_push(fifo_push), .fifo_word(fifo_word), .mbox_data(mbox_data),
        .par_err(par_err)
    );

    localparam logic [8:0] BA = 9'h1A1;
    localparam logic [8:0] BB = 9'h0B2;
    localparam logic [8:0] BC = 9'h1C3;
    localparam logic [8:0] BD = 9'h0D4;
    localparam logic [35:0] W_ABCD = {BA, BB, BC, BD};
    localparam logic [35:0] W_DCBA = {BD, BC, BB, BA};

    // Vector table: mode, lane, four written bytes (first in the top slot), expected word.
    localparam int NV = 6;
    localparam logic [1:0]  V_MODE [NV] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b00, 2'b01};
    localparam logic        V_BIG  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam logic [35:0] V_WR   [NV] = '{
        {BA, BB, BC, BD}, {BD, BC, BB, BA}, {BC, BD, BA, BB},
        {BB, BA, BD, BC}, {BD, BC, BB, BA}, {BA, BB, BC, BD}};
    localparam logic [35:0] V_EXP  [NV] = '{W_ABCD, W_ABCD, W_ABCD, W_ABCD, W_DCBA, W_DCBA};
    localparam string       V_REQ  [NV] = '{"R1", "R4 R2", "R5", "R6 R2", "R1 R2", "R4"};

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one access at a falling edge; return at the next falling edge.
    task automatic put(input logic [8:0] b, input logic big, input logic [1:0] md,
                       input logic csn, input logic wr, input logic e,
                       input logic full, input logic [1:0] sz);
        sel_n = csn; wr_mode = wr; en = e; fifo_full = full; size_code = sz;
        swap_mode = md; big_lane = big;
        din = big ? {b, 27'h2AAAAAA} : {27'h5555555, b};
        @(negedge clk);
        sel_n = 1'b1; en = 1'b0; fifo_full = 1'b0; size_code = 2'b00;
    endtask

    task automatic good(input logic [8:0] b, input logic big, input logic [1:0] md);
        put(b, big, md, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state.
        check("R11 push at reset", 36'(fifo_push), 36'd0);
        check("R11 mbox at reset", mbox_data, 36'd0);
        check("R11 word at reset", fifo_word, 36'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: placement per swap mode and lane.
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < 4; k++) begin
                good(V_WR[v][(3-k)*9 +: 9], V_BIG[v], V_MODE[v]);
                if (k < 3) check({V_REQ[v], " R3 no early push"}, 36'(fifo_push), 36'd0);
            end
            check({V_REQ[v], " R3 push"}, 36'(fifo_push), 36'd1);
            check({V_REQ[v], " word"}, fifo_word, V_EXP[v]);
            @(negedge clk);
            check("R3 push one cycle", 36'(fifo_push), 36'd0);
        end

        // R7: mode change after the first byte is ignored.
        good(BA, 1'b1, 2'b00);
        good(BB, 1'b1, 2'b01);
        good(BC, 1'b1, 2'b10);
        good(BD, 1'b1, 2'b11);
        check("R7 push", 36'(fifo_push), 36'd1);
        check("R7 mode held", fifo_word, W_ABCD);

        // R8: blocked attempts mid-word do not count or place bytes.
        good(BA, 1'b1, 2'b00);
        put(9'h1FF, 1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00);
        put(9'h1FF, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00);
        put(9'h1FF, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00);
        put(9'h1FF, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00);
        check("R8 no push from blocked", 36'(fifo_push), 36'd0);
        good(BB, 1'b1, 2'b00);
        good(BC, 1'b1, 2'b00);
        check("R8 count unchanged", 36'(fifo_push), 36'd0);
        good(BD, 1'b1, 2'b00);
        check("R8 push", 36'(fifo_push), 36'd1);
        check("R8 word", fifo_word, W_ABCD);

        // R9: mailbox write mid-word, with full set.
        good(BD, 1'b0, 2'b01);
        good(BC, 1'b0, 2'b01);
        put(9'h155, 1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11);
        check("R9 mailbox loaded", mbox_data, {9'h155, 27'h2AAAAAA});
        check("R9 no push", 36'(fifo_push), 36'd0);
        good(BB, 1'b0, 2'b01);
        check("R9 mailbox held", mbox_data, {9'h155, 27'h2AAAAAA});
        good(BA, 1'b0, 2'b01);
        check("R9 push", 36'(fifo_push), 36'd1);
        check("R9 word intact", fifo_word, W_ABCD);

        // R10: parity of the active lane.
        din = {9'h001, 27'h0}; big_lane = 1'b1; odd_par = 1'b1; #1;
        check("R10 big odd ok", 36'(par_err), 36'd0);
        odd_par = 1'b0; #1;
        check("R10 big even err", 36'(par_err), 36'd1);
        din = {9'h001, 9'h000, 9'h003, 9'h000}; big_lane = 1'b0; odd_par = 1'b1; #1;
        check("R10 little odd err", 36'(par_err), 36'd1);
        odd_par = 1'b0; #1;
        check("R10 little even ok", 36'(par_err), 36'd0);
        @(negedge clk);

        // R11: reset drops a partial word.
        good(9'h111, 1'b1, 2'b00);
        good(9'h122, 1'b1, 2'b00);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 mbox cleared", mbox_data, 36'd0);
        rst_n = 1'b1;
        good(BA, 1'b1, 2'b00);
        good(BB, 1'b1, 2'b00);
        check("R11 no push at old count", 36'(fifo_push), 36'd0);
        good(BC, 1'b1, 2'b00);
        good(BD, 1'b1, 2'b00);
        check("R11 push", 36'(fifo_push), 36'd1);
        check("R11 fresh word", fifo_word, W_ABCD);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule